// File: doc/BRIEF.md
# Decode-Stage Branch Target Check and Redirect

This block sits directly behind instruction decode. Each cycle it receives a group of up to `NSLOT` decoded instruction records in program order. For every slot holding a direct control transfer that is either unconditional or predicted taken, it compares the target calculated at decode with the target the front-end predictor supplied. A disagreement means fetch went down the wrong path. The block then raises a squash and mispredict redirect toward fetch, carrying the corrected next PC.

Only the first offending slot in slot order produces the redirect. Along with it comes a kill mask that marks every valid slot of the same thread that is younger than the offender, so those instructions are dropped. Slots of other threads are left untouched. A separate error flag reports a predictor fault: a slot marked predicted taken that is not a control instruction at all. Every output is registered, so a redirect appears one clock after the group that caused it and lasts one cycle.

Top module: `branch_redirect_check`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, every output is 0.
- R2: A slot is examined only if it is valid, direct, and either unconditional or predicted taken. A target mismatch on any other slot (indirect, or conditional and not predicted taken) causes no redirect, kill or change of any output.
- R3: When an examined slot's calculated target differs from its predicted target, `redir_valid_o` and `redir_mispredict_o` are both 1. `redir_pc_o` equals that slot's calculated target and `redir_tid_o` equals its thread.
- R4: `redir_seq_o` equals the sequence number of the offending slot, which is the last correctly predicted instruction.
- R5: `redir_taken_o` equals the slot's `slot_branching_i` bit, except that it is 1 whenever the offending slot is unconditional.
- R6: `kill_mask_o[j]` is 1 exactly when a redirect is raised, slot j is valid, has the offender's thread, and has a sequence number strictly greater (unsigned) than the offender's. Bit j corresponds to slot j.
- R7: When several slots mismatch in the same group, the lowest slot index wins. The offender's own kill bit is never set.
- R8: Outputs for a group applied before rising edge N appear after edge N and hold for exactly that one cycle. With no new offending group, all redirect outputs and the kill mask return to 0 after edge N+1.
- R9: `ctrl_err_o` is 1 in the cycle after a group containing a valid slot that is predicted taken while `slot_is_ctrl_i` is 0. It follows the same one-cycle timing and is independent of the redirect.
- R10: When every examined slot's two targets agree, no redirect is raised and the kill mask is 0.
- R11: Slot fields are packed least significant slot first: slot i occupies bits [i*W +: W] of each wide input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_valid_i | input | NSLOT | Slot holds an instruction |
| slot_tid_i | input | NSLOT*TID_W | Thread of each slot |
| slot_seq_i | input | NSLOT*SEQ_W | Sequence number of each slot |
| slot_direct_i | input | NSLOT | Direct control transfer |
| slot_uncond_i | input | NSLOT | Unconditional control transfer |
| slot_pred_taken_i | input | NSLOT | Predictor said taken |
| slot_is_ctrl_i | input | NSLOT | Instruction is a control transfer |
| slot_branching_i | input | NSLOT | Branch outcome flag of the slot |
| slot_calc_tgt_i | input | NSLOT*PC_W | Target calculated at decode |
| slot_pred_tgt_i | input | NSLOT*PC_W | Target supplied by the predictor |
| redir_valid_o | output | 1 | Squash request to fetch |
| redir_mispredict_o | output | 1 | Branch mispredict indication |
| redir_tid_o | output | TID_W | Thread to redirect |
| redir_seq_o | output | SEQ_W | Sequence number of last correct instruction |
| redir_pc_o | output | PC_W | Corrected next PC |
| redir_taken_o | output | 1 | Taken flag of the offending branch |
| kill_mask_o | output | NSLOT | Slots of the group to be discarded |
| ctrl_err_o | output | 1 | Predicted-taken non-control instruction seen |

## Verification
Every result of this block, including the redirect bundle, the kill mask and the error flag, is due exactly one rising edge after the group that produced it. The bench drives each group on a falling edge. At the next falling edge it compares all outputs with a prediction its own model computed from that group. Because the comparison happens every cycle, it also catches a redirect or kill bit that lingers one cycle too long, or one that arrives a cycle early.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned DEF_NSLOT = 4;
  localparam int unsigned DEF_TID_W = 1;
  localparam int unsigned DEF_SEQ_W = 16;
  localparam int unsigned DEF_PC_W  = 32;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/brc_slot_check.sv
module brc_slot_check #(
  parameter int unsigned PC_W = 32
) (
  input  logic            valid_i,
  input  logic            direct_i,
  input  logic            uncond_i,
  input  logic            pred_taken_i,
  input  logic            is_ctrl_i,
  input  logic [PC_W-1:0] calc_tgt_i,
  input  logic [PC_W-1:0] pred_tgt_i,
  output logic            mismatch_o,
  output logic            bad_pred_o
);
  logic eligible;

  // resolvable at decode: direct and (unconditional or predicted taken)
  assign eligible   = valid_i & direct_i & (uncond_i | pred_taken_i);
  assign mismatch_o = eligible & (calc_tgt_i != pred_tgt_i);
  assign bad_pred_o = valid_i & pred_taken_i & ~is_ctrl_i;
endmodule

// File: rtl/brc_pick.sv
module brc_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/brc_kill.sv
module brc_kill #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 1,
  parameter int unsigned SEQ_W = 16
) (
  input  logic               any_i,
  input  logic [TID_W-1:0]   sel_tid_i,
  input  logic [SEQ_W-1:0]   sel_seq_i,
  input  logic [N-1:0]       valid_i,
  input  logic [N*TID_W-1:0] tid_i,
  input  logic [N*SEQ_W-1:0] seq_i,
  output logic [N-1:0]       kill_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic same_thr, younger;
    assign same_thr  = (tid_i[g*TID_W +: TID_W] == sel_tid_i);
    assign younger   = (seq_i[g*SEQ_W +: SEQ_W] > sel_seq_i);
    assign kill_o[g] = any_i & valid_i[g] & same_thr & younger;
  end
endmodule

// File: rtl/branch_redirect_check.sv
module branch_redirect_check
  import brc_pkg::*;
#(
  parameter int unsigned NSLOT = DEF_NSLOT,
  parameter int unsigned TID_W = DEF_TID_W,
  parameter int unsigned SEQ_W = DEF_SEQ_W,
  parameter int unsigned PC_W  = DEF_PC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSLOT-1:0]       slot_valid_i,
  input  logic [NSLOT*TID_W-1:0] slot_tid_i,
  input  logic [NSLOT*SEQ_W-1:0] slot_seq_i,
  input  logic [NSLOT-1:0]       slot_direct_i,
  input  logic [NSLOT-1:0]       slot_uncond_i,
  input  logic [NSLOT-1:0]       slot_pred_taken_i,
  input  logic [NSLOT-1:0]       slot_is_ctrl_i,
  input  logic [NSLOT-1:0]       slot_branching_i,
  input  logic [NSLOT*PC_W-1:0]  slot_calc_tgt_i,
  input  logic [NSLOT*PC_W-1:0]  slot_pred_tgt_i,
  output logic                   redir_valid_o,
  output logic                   redir_mispredict_o,
  output logic [TID_W-1:0]       redir_tid_o,
  output logic [SEQ_W-1:0]       redir_seq_o,
  output logic [PC_W-1:0]        redir_pc_o,
  output logic                   redir_taken_o,
  output logic [NSLOT-1:0]       kill_mask_o,
  output logic                   ctrl_err_o
);
  logic [NSLOT-1:0] mismatch, bad_pred, gnt, kill_d;
  logic             any_d;
  logic [TID_W-1:0] sel_tid;
  logic [SEQ_W-1:0] sel_seq;
  logic [PC_W-1:0]  sel_pc;
  logic             sel_taken;

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    brc_slot_check #(.PC_W(PC_W)) u_chk (
      .valid_i      (slot_valid_i[g]),
      .direct_i     (slot_direct_i[g]),
      .uncond_i     (slot_uncond_i[g]),
      .pred_taken_i (slot_pred_taken_i[g]),
      .is_ctrl_i    (slot_is_ctrl_i[g]),
      .calc_tgt_i   (slot_calc_tgt_i[g*PC_W +: PC_W]),
      .pred_tgt_i   (slot_pred_tgt_i[g*PC_W +: PC_W]),
      .mismatch_o   (mismatch[g]),
      .bad_pred_o   (bad_pred[g])
    );
  end

  brc_pick #(.N(NSLOT)) u_pick (
    .req_i (mismatch),
    .gnt_o (gnt),
    .any_o (any_d)
  );

  // one-hot AND-OR select: all zero when nothing granted
  always_comb begin
    sel_tid   = '0;
    sel_seq   = '0;
    sel_pc    = '0;
    sel_taken = 1'b0;
    for (int i = 0; i < int'(NSLOT); i++) begin
      if (gnt[i]) begin
        sel_tid   = sel_tid | slot_tid_i[i*TID_W +: TID_W];
        sel_seq   = sel_seq | slot_seq_i[i*SEQ_W +: SEQ_W];
        sel_pc    = sel_pc  | slot_calc_tgt_i[i*PC_W +: PC_W];
        sel_taken = sel_taken | slot_branching_i[i] | slot_uncond_i[i];
      end
    end
  end

  brc_kill #(.N(NSLOT), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_kill (
    .any_i     (any_d),
    .sel_tid_i (sel_tid),
    .sel_seq_i (sel_seq),
    .valid_i   (slot_valid_i),
    .tid_i     (slot_tid_i),
    .seq_i     (slot_seq_i),
    .kill_o    (kill_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_valid_o      <= 1'b0;
      redir_mispredict_o <= 1'b0;
      redir_tid_o        <= '0;
      redir_seq_o        <= '0;
      redir_pc_o         <= '0;
      redir_taken_o      <= 1'b0;
      kill_mask_o        <= '0;
      ctrl_err_o         <= 1'b0;
    end else begin
      redir_valid_o      <= any_d;
      redir_mispredict_o <= any_d;
      redir_tid_o        <= sel_tid;
      redir_seq_o        <= sel_seq;
      redir_pc_o         <= sel_pc;
      redir_taken_o      <= sel_taken;
      kill_mask_o        <= kill_d;
      ctrl_err_o         <= |bad_pred;
    end
  end
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int unsigned NSLOT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSLOT-1:0] slot_valid_i,
  input logic [NSLOT-1:0] slot_pred_taken_i,
  input logic [NSLOT-1:0] slot_is_ctrl_i,
  input logic             redir_valid_o,
  input logic             redir_mispredict_o,
  input logic [NSLOT-1:0] kill_mask_o,
  input logic             ctrl_err_o
);
  p_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_o == redir_mispredict_o);

  p_kill_needs_redir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|kill_mask_o) |-> redir_valid_o);

  p_offender_spared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(kill_mask_o) < NSLOT);

  p_redir_has_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_o |-> $past(|slot_valid_i));

  p_err_has_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_err_o |-> $past(|(slot_valid_i & slot_pred_taken_i & ~slot_is_ctrl_i)));
endmodule

bind branch_redirect_check brc_checker #(.NSLOT(NSLOT)) u_brc_checker (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .slot_valid_i      (slot_valid_i),
  .slot_pred_taken_i (slot_pred_taken_i),
  .slot_is_ctrl_i    (slot_is_ctrl_i),
  .redir_valid_o     (redir_valid_o),
  .redir_mispredict_o(redir_mispredict_o),
  .kill_mask_o       (kill_mask_o),
  .ctrl_err_o        (ctrl_err_o)
);

// File: tb/branch_redirect_check_tb_top.sv
module branch_redirect_check_tb_top;
  localparam int N = 4;
  localparam int TW = 1;
  localparam int SW = 16;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    v, dir, unc, pt, ctl, br;
  logic [N*TW-1:0] tid;
  logic [N*SW-1:0] seq;
  logic [N*PW-1:0] calc, pred;

  logic          r_valid, r_misp, r_taken, c_err;
  logic [TW-1:0] r_tid;
  logic [SW-1:0] r_seq;
  logic [PW-1:0] r_pc;
  logic [N-1:0]  kmask;

  branch_redirect_check dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_valid_i(v), .slot_tid_i(tid), .slot_seq_i(seq),
    .slot_direct_i(dir), .slot_uncond_i(unc), .slot_pred_taken_i(pt),
    .slot_is_ctrl_i(ctl), .slot_branching_i(br),
    .slot_calc_tgt_i(calc), .slot_pred_tgt_i(pred),
    .redir_valid_o(r_valid), .redir_mispredict_o(r_misp),
    .redir_tid_o(r_tid), .redir_seq_o(r_seq), .redir_pc_o(r_pc),
    .redir_taken_o(r_taken), .kill_mask_o(kmask), .ctrl_err_o(c_err)
  );

  int checks = 0;
  int fails  = 0;

  logic          e_valid, e_taken, e_err;
  logic [TW-1:0] e_tid;
  logic [SW-1:0] e_seq;
  logic [PW-1:0] e_pc;
  logic [N-1:0]  e_kill;

  task automatic chk(input string req, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    v = '0; dir = '0; unc = '0; pt = '0; ctl = '0; br = '0;
    tid = '0; seq = '0; calc = '0; pred = '0;
  endtask

  task automatic put(input int i, input logic vv, input int t, input int s,
                     input logic d, input logic u, input logic p,
                     input logic c, input logic b, input int ct, input int pr);
    v[i] = vv; tid[i*TW +: TW] = TW'(t); seq[i*SW +: SW] = SW'(s);
    dir[i] = d; unc[i] = u; pt[i] = p; ctl[i] = c; br[i] = b;
    calc[i*PW +: PW] = PW'(ct); pred[i*PW +: PW] = PW'(pr);
  endtask

  // behavioural reference of one group
  task automatic model();
    int off;
    off = -1;
    e_err = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && pt[i] && !ctl[i]) e_err = 1'b1;
      if (off < 0 && v[i] && dir[i] && (unc[i] || pt[i]) &&
          calc[i*PW +: PW] != pred[i*PW +: PW]) off = i;
    end
    e_valid = (off >= 0);
    e_tid = '0; e_seq = '0; e_pc = '0; e_taken = 1'b0; e_kill = '0;
    if (off >= 0) begin
      e_tid   = tid[off*TW +: TW];
      e_seq   = seq[off*SW +: SW];
      e_pc    = calc[off*PW +: PW];
      e_taken = unc[off] ? 1'b1 : br[off];
      for (int j = 0; j < N; j++)
        e_kill[j] = v[j] && (tid[j*TW +: TW] == e_tid) && (seq[j*SW +: SW] > e_seq);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " R3"}, "valid", PW'(r_valid), PW'(e_valid));
    chk({tag, " R3"}, "mispredict", PW'(r_misp), PW'(e_valid));
    chk({tag, " R3"}, "pc", r_pc, e_pc);
    chk({tag, " R3"}, "tid", PW'(r_tid), PW'(e_tid));
    chk({tag, " R4"}, "seq", PW'(r_seq), PW'(e_seq));
    chk({tag, " R5"}, "taken", PW'(r_taken), PW'(e_taken));
    chk({tag, " R6"}, "kill", PW'(kmask), PW'(e_kill));
    chk({tag, " R9"}, "err", PW'(c_err), PW'(e_err));
  endtask

  // group is driven now; result due after next rising edge
  task automatic step(input string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clear_all();
    #1;
    // R1: reset state
    e_valid = 0; e_taken = 0; e_err = 0; e_tid = '0; e_seq = '0; e_pc = '0; e_kill = '0;
    compare("R1 reset");
    // drive noise during reset, outputs must stay zero
    put(0, 1, 0, 5, 1, 1, 0, 1, 0, 100, 200);
    @(negedge clk); @(negedge clk);
    compare("R1 in-reset");
    clear_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after-release");

    // R10: matching targets
    put(0, 1, 0, 10, 1, 1, 0, 1, 1, 64, 64);
    put(1, 1, 0, 11, 1, 0, 1, 1, 1, 80, 80);
    step("R10 match");

    // R2: ineligible mismatches ignored
    clear_all();
    put(0, 1, 0, 20, 1, 0, 0, 1, 0, 4, 8);   // cond not predicted taken
    put(1, 1, 0, 21, 0, 1, 1, 1, 1, 12, 16); // indirect
    put(2, 1, 0, 22, 1, 1, 0, 1, 1, 7, 9);   // invalid below
    v[2] = 1'b0;
    step("R2 ineligible");

    // R3 R4 R5 R6: uncond mismatch at slot 2
    clear_all();
    put(0, 1, 0, 30, 0, 0, 0, 0, 0, 0, 0);
    put(1, 1, 1, 35, 0, 0, 0, 0, 0, 0, 0);
    put(2, 1, 0, 31, 1, 1, 0, 1, 0, 32'h400, 32'h500);
    put(3, 1, 0, 32, 0, 0, 0, 0, 0, 0, 0);
    step("R3 uncond");

    // R8: pulse ends with idle group
    clear_all();
    step("R8 idle");

    // R5: predicted-taken conditional, outcome flag 0
    put(0, 1, 1, 40, 1, 0, 1, 1, 0, 32'h1000, 32'h2000);
    put(1, 1, 1, 41, 0, 0, 0, 0, 0, 0, 0);
    put(2, 1, 0, 42, 0, 0, 0, 0, 0, 0, 0);
    step("R5 cond");

    // R7: two offenders, lowest slot wins
    clear_all();
    put(0, 1, 0, 50, 0, 0, 0, 0, 0, 0, 0);
    put(1, 1, 0, 51, 1, 1, 0, 1, 1, 32'h111, 32'h222);
    put(2, 1, 0, 52, 0, 0, 0, 0, 0, 0, 0);
    put(3, 1, 0, 53, 1, 1, 0, 1, 1, 32'h333, 32'h444);
    step("R7 oldest");
    // R8: back-to-back redirects
    step("R8 repeat");

    // R9: predicted-taken non-control
    clear_all();
    put(2, 1, 0, 60, 0, 0, 1, 0, 0, 0, 0);
    step("R9 err");
    clear_all();
    step("R9 clear");

    // R11 + random mix
    for (int k = 0; k < 400; k++) begin
      clear_all();
      for (int i = 0; i < N; i++)
        put(i, 1'($urandom), int'($urandom_range(0, 1)), int'($urandom_range(0, 40)),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      step("R11 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule